// File: doc/BRIEF.md
# Ordered Store Write-Back Ring

This block keeps the stores of one hardware thread of an out-of-order core in a circular buffer, oldest at the head. The rename stage reserves a slot at the tail for every store, in program order, and receives the slot index back. The execute stage later writes the address, byte size and data into that slot. When the commit stage retires a group of instructions, it sends a sequence number. Every store older than that number is then allowed to write to memory.

A separate write-back pointer walks from the oldest store towards the tail. It presents one committed store at a time to a single memory request port. The memory side may refuse a request. The block then holds the same store until a retry pulse arrives. Acknowledgements mark stores completed, and a slot returns to the free pool only when it is the head and is completed. A squash carrying a sequence number discards every younger store by pulling the tail back. One slot always stays unused so that equal pointers can mean only "empty".

Top module: `stq_ring`

## Requirements
- R1: With the default of 8 slots, at most 7 stores are held. When 7 are held, `full` is 1 and `alloc_ready` is 0, and an allocation request leaves `count` and `alloc_idx` unchanged.
- R2: Each accepted allocation takes the slot at `alloc_idx`. `alloc_idx` then steps by one and wraps from 7 back to 0, so slot indices follow program order around the ring.
- R3: The address, size and data written to a slot through the fill port are exactly the values shown on `mem_req_addr`, `mem_req_size` and `mem_req_data` when that slot is written back.
- R4: A store that has not been committed is never presented to memory: `mem_req_valid` stays 0 while the store at the write-back pointer is uncommitted.
- R5: A commit with sequence number N marks every held store whose sequence number is below N as committed. `pending_wb` rises by the number of stores newly marked, one cycle later.
- R6: Write-back requests go out in slot order, one store per accepted request. `mem_req_idx` advances by one (with wrap) in the cycle after each accept.
- R7: When `mem_req_valid` is 1 and `mem_req_accept` is 0 at a clock edge, `wb_blocked` becomes 1 and `mem_req_valid` drops to 0 with `mem_req_idx` unchanged. A `mem_retry` pulse clears the block, and the same slot is then presented again.
- R8: An acknowledgement marks its slot completed and lowers `pending_wb` by one. A slot is released only from the head: `count` falls one cycle after the head slot is completed, by at most one per cycle. A completed slot behind an uncompleted head is not released.
- R9: A squash with sequence number S removes every store whose sequence number is above S. `count` becomes the number kept, and `alloc_idx` moves back to the slot after the youngest kept store. An allocation request in the same cycle as a squash is ignored.
- R10: After reset the ring is empty: `count` 0, `empty` 1, `pending_wb` 0, `mem_req_valid` 0, `alloc_idx` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Request to reserve a slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IDX_W | Slot the next allocation takes (tail) |
| fill_valid | input | 1 | Execute stage writes a slot's payload |
| fill_idx | input | IDX_W | Slot being filled |
| fill_addr | input | ADDR_W | Store address |
| fill_size | input | SIZE_W | Store size in bytes |
| fill_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Stores older than this are committed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| mem_req_valid | output | 1 | Write-back request present |
| mem_req_idx | output | IDX_W | Slot at the write-back pointer |
| mem_req_addr | output | ADDR_W | Address of the presented store |
| mem_req_size | output | SIZE_W | Size of the presented store |
| mem_req_data | output | DATA_W | Data of the presented store |
| mem_req_accept | input | 1 | Memory takes the request this cycle |
| mem_retry | input | 1 | Memory can accept again after a refusal |
| mem_ack_valid | input | 1 | Write of a slot has finished |
| mem_ack_idx | input | IDX_W | Slot whose write finished |
| wb_blocked | output | 1 | A refused request waits for a retry |
| full | output | 1 | Usable capacity reached |
| empty | output | 1 | No store held |
| count | output | CNT_W | Number of stores held |
| pending_wb | output | CNT_W | Committed stores not yet completed |

## Verification
The write-back path is driven three ways: a partial commit that covers only the oldest three stores, a refusal followed by a retry, and a full commit after the ring has wrapped. Together they separate "committed and eligible" from "merely allocated", and they show that a refusal pins the pointer instead of skipping a store. Acknowledgements arrive out of order, so the bench can tell head-only release apart from release on any completion. The squash is issued together with an allocation and lands in the middle of the ring. This checks both where the tail lands and that the concurrent allocation is dropped.

// File: rtl/stq_pkg.sv
// Package: ring-index arithmetic shared by the store ring modules.
// Assumes indices and counts are small non-negative integers below `slots`.
package stq_pkg;

    // Advance index p by n positions in a ring of `slots` entries (n < slots).
    function automatic int unsigned ring_add(int unsigned p, int unsigned n,
                                             int unsigned slots);
        int unsigned s;
        s = p + n;
        return (s >= slots) ? s - slots : s;
    endfunction

    // Number of steps from index `from` forward to index `to` in the ring.
    function automatic int unsigned ring_dist(int unsigned from, int unsigned to,
                                              int unsigned slots);
        return (to >= from) ? to - from : to + slots - from;
    endfunction

endpackage

// File: rtl/stq_slot.sv
// Module: one store ring slot, holding the sequence tag, payload and state flags.
// Assumes the controller never raises alloc_hit and release_hit together and
// never allocates a slot that is still valid.
module stq_slot #(
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_hit,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              fill_hit,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [SIZE_W-1:0] fill_size,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              commit_req,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_req,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              ack_hit,
    input  logic              release_hit,
    output logic              valid_o,
    output logic [SEQ_W-1:0]  seq_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SIZE_W-1:0] size_o,
    output logic [DATA_W-1:0] data_o,
    output logic              can_wb_o,
    output logic              committed_o,
    output logic              completed_o,
    output logic              commit_now_o,
    output logic              keep_o
);

    logic              valid_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [DATA_W-1:0] data_q;
    logic              can_wb_q;
    logic              committed_q;
    logic              completed_q;

    // Decode whether this cycle's commit newly retires this store.
    always_comb begin
        commit_now_o = commit_req && valid_q && !committed_q && (seq_q < commit_seq);
    end

    // Decode whether this store survives a squash at squash_seq.
    always_comb begin
        keep_o = valid_q && (seq_q <= squash_seq);
    end

    // Maintain occupancy, tag and the three life-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q     <= 1'b0;
            seq_q       <= '0;
            can_wb_q    <= 1'b0;
            committed_q <= 1'b0;
            completed_q <= 1'b0;
        end else if (release_hit || (squash_req && valid_q && !keep_o)) begin
            valid_q     <= 1'b0;
            can_wb_q    <= 1'b0;
            committed_q <= 1'b0;
            completed_q <= 1'b0;
        end else if (alloc_hit) begin
            valid_q     <= 1'b1;
            seq_q       <= alloc_seq;
            can_wb_q    <= 1'b0;
            committed_q <= 1'b0;
            completed_q <= 1'b0;
        end else begin
            if (commit_now_o) begin
                committed_q <= 1'b1;
                can_wb_q    <= 1'b1;
            end
            if (ack_hit) begin
                completed_q <= 1'b1;
            end
        end
    end

    // Capture the payload from the execute stage; a fresh allocation clears the size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= '0;
            data_q <= '0;
        end else if (fill_hit) begin
            addr_q <= fill_addr;
            size_q <= fill_size;
            data_q <= fill_data;
        end else if (alloc_hit) begin
            size_q <= '0;
        end
    end

    assign valid_o     = valid_q;
    assign seq_o       = seq_q;
    assign addr_o      = addr_q;
    assign size_o      = size_q;
    assign data_o      = data_q;
    assign can_wb_o    = can_wb_q;
    assign committed_o = committed_q;
    assign completed_o = completed_q;

endmodule

// File: rtl/stq_ring_ctl.sv
// Module: head/tail/occupancy control for the store ring with one sentinel slot.
// Assumes keep_cnt is the size of the contiguous oldest run that survives a
// squash, and that only the head slot's completion drives head_done.
module stq_ring_ctl #(
    parameter int SLOTS = 8,
    parameter int IDX_W = $clog2(SLOTS),
    parameter int CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             squash_req,
    input  logic [CNT_W-1:0] keep_cnt,
    input  logic             head_done,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             alloc_fire_o,
    output logic             release_fire_o
);

    localparam int CAP = SLOTS - 1;

    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_q;
    logic [CNT_W-1:0] count_q;

    // Flag full when every usable slot is taken (the sentinel stays free).
    always_comb begin
        full_o = (32'(count_q) == CAP);
    end

    // Accept an allocation only when a slot is free and no squash is in flight.
    always_comb begin
        alloc_fire_o   = alloc_req && !full_o && !squash_req;
        release_fire_o = head_done;
    end

    // Advance head on release, and move tail forward on allocation or back on squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (release_fire_o) begin
                head_q <= IDX_W'(stq_pkg::ring_add(32'(head_q), 1, SLOTS));
            end
            if (squash_req) begin
                tail_q  <= IDX_W'(stq_pkg::ring_add(32'(head_q), 32'(keep_cnt), SLOTS));
                count_q <= keep_cnt - CNT_W'(release_fire_o);
            end else begin
                if (alloc_fire_o) begin
                    tail_q <= IDX_W'(stq_pkg::ring_add(32'(tail_q), 1, SLOTS));
                end
                count_q <= count_q + CNT_W'(alloc_fire_o) - CNT_W'(release_fire_o);
            end
        end
    end

    assign head_o  = head_q;
    assign tail_o  = tail_q;
    assign count_o = count_q;

endmodule

// File: rtl/stq_wb_ctrl.sv
// Module: write-back pointer and refusal/retry handling for the memory port.
// Assumes squashed stores are never committed, so a squash can only cut the
// ring at or beyond the write-back pointer.
module stq_wb_ctrl #(
    parameter int SLOTS = 8,
    parameter int IDX_W = $clog2(SLOTS),
    parameter int CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eligible,
    input  logic             accept,
    input  logic             retry,
    input  logic             squash_req,
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] keep_cnt,
    output logic [IDX_W-1:0] wb_ptr_o,
    output logic             req_valid_o,
    output logic             blocked_o
);

    logic [IDX_W-1:0] wb_ptr_q;
    logic             blocked_q;
    logic             past_cut;

    // Present a request only when the pointed store may go and no refusal is pending.
    always_comb begin
        req_valid_o = eligible && !blocked_q;
    end

    // Detect a write-back pointer that would end up beyond the squashed tail.
    always_comb begin
        past_cut = stq_pkg::ring_dist(32'(head), 32'(wb_ptr_q), SLOTS) > 32'(keep_cnt);
    end

    // Step the pointer on an accepted request; clamp it to the new tail on a squash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_ptr_q <= '0;
        end else if (req_valid_o && accept) begin
            wb_ptr_q <= IDX_W'(stq_pkg::ring_add(32'(wb_ptr_q), 1, SLOTS));
        end else if (squash_req && past_cut) begin
            wb_ptr_q <= IDX_W'(stq_pkg::ring_add(32'(head), 32'(keep_cnt), SLOTS));
        end
    end

    // Hold the blocked state from a refusal until the memory side signals retry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q <= 1'b0;
        end else if (req_valid_o && !accept) begin
            blocked_q <= 1'b1;
        end else if (retry) begin
            blocked_q <= 1'b0;
        end
    end

    assign wb_ptr_o  = wb_ptr_q;
    assign blocked_o = blocked_q;

endmodule

// File: rtl/stq_ring.sv
// Module: per-thread store ring with head, write-back and tail pointers.
// Assumes sequence numbers rise monotonically without wrapping while held,
// commit and squash are not raised in the same cycle, and a fill targets an
// allocated slot.
module stq_ring #(
    parameter int CAP    = 7,
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SLOTS  = CAP + 1,
    parameter int IDX_W  = $clog2(SLOTS),
    parameter int CNT_W  = $clog2(SLOTS),
    parameter int SIZE_W = $clog2(DATA_W / 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [SIZE_W-1:0] fill_size,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              mem_req_valid,
    output logic [IDX_W-1:0]  mem_req_idx,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [SIZE_W-1:0] mem_req_size,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_req_accept,
    input  logic              mem_retry,
    input  logic              mem_ack_valid,
    input  logic [IDX_W-1:0]  mem_ack_idx,
    output logic              wb_blocked,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  pending_wb
);

    logic [SLOTS-1:0]  s_valid;
    logic [SLOTS-1:0]  s_can_wb;
    logic [SLOTS-1:0]  s_committed;
    logic [SLOTS-1:0]  s_completed;
    logic [SLOTS-1:0]  s_commit_now;
    logic [SLOTS-1:0]  s_keep;
    logic [SLOTS-1:0]  s_ack;
    logic [SEQ_W-1:0]  s_seq  [SLOTS];
    logic [ADDR_W-1:0] s_addr [SLOTS];
    logic [SIZE_W-1:0] s_size [SLOTS];
    logic [DATA_W-1:0] s_data [SLOTS];

    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  tail;
    logic [IDX_W-1:0]  wb_ptr;
    logic [CNT_W-1:0]  keep_cnt;
    logic [CNT_W-1:0]  commit_cnt;
    logic              alloc_fire;
    logic              release_fire;
    logic              head_done;
    logic              wb_eligible;
    logic              ring_full;
    logic [CNT_W-1:0]  pending_q;

    // Count survivors of a squash and stores newly retired by a commit.
    always_comb begin
        keep_cnt   = CNT_W'($countones(s_keep));
        commit_cnt = CNT_W'($countones(s_commit_now));
    end

    // Look up the head and write-back slots' state.
    always_comb begin
        head_done   = s_valid[head] && s_completed[head];
        wb_eligible = s_valid[wb_ptr] && s_can_wb[wb_ptr] && !s_completed[wb_ptr];
    end

    // One slot per ring position.
    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        // Accept an acknowledgement only for a committed, not yet completed slot.
        assign s_ack[gi] = mem_ack_valid && (32'(mem_ack_idx) == gi) &&
                           s_valid[gi] && s_can_wb[gi] && !s_completed[gi];

        stq_slot #(
            .SEQ_W (SEQ_W),
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W),
            .SIZE_W(SIZE_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_hit   (alloc_fire && (32'(tail) == gi)),
            .alloc_seq   (alloc_seq),
            .fill_hit    (fill_valid && (32'(fill_idx) == gi)),
            .fill_addr   (fill_addr),
            .fill_size   (fill_size),
            .fill_data   (fill_data),
            .commit_req  (commit_valid),
            .commit_seq  (commit_seq),
            .squash_req  (squash_valid),
            .squash_seq  (squash_seq),
            .ack_hit     (s_ack[gi]),
            .release_hit (release_fire && (32'(head) == gi)),
            .valid_o     (s_valid[gi]),
            .seq_o       (s_seq[gi]),
            .addr_o      (s_addr[gi]),
            .size_o      (s_size[gi]),
            .data_o      (s_data[gi]),
            .can_wb_o    (s_can_wb[gi]),
            .committed_o (s_committed[gi]),
            .completed_o (s_completed[gi]),
            .commit_now_o(s_commit_now[gi]),
            .keep_o      (s_keep[gi])
        );
    end

    stq_ring_ctl #(
        .SLOTS(SLOTS),
        .IDX_W(IDX_W),
        .CNT_W(CNT_W)
    ) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_req     (alloc_valid),
        .squash_req    (squash_valid),
        .keep_cnt      (keep_cnt),
        .head_done     (head_done),
        .head_o        (head),
        .tail_o        (tail),
        .count_o       (count),
        .full_o        (ring_full),
        .alloc_fire_o  (alloc_fire),
        .release_fire_o(release_fire)
    );

    stq_wb_ctrl #(
        .SLOTS(SLOTS),
        .IDX_W(IDX_W),
        .CNT_W(CNT_W)
    ) u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (wb_eligible),
        .accept     (mem_req_accept),
        .retry      (mem_retry),
        .squash_req (squash_valid),
        .head       (head),
        .keep_cnt   (keep_cnt),
        .wb_ptr_o   (wb_ptr),
        .req_valid_o(mem_req_valid),
        .blocked_o  (wb_blocked)
    );

    // Track committed stores still waiting for their write to finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else begin
            pending_q <= pending_q + commit_cnt - CNT_W'(|s_ack);
        end
    end

    // Drive the request payload from the write-back slot and the status outputs.
    always_comb begin
        mem_req_idx  = wb_ptr;
        mem_req_addr = s_addr[wb_ptr];
        mem_req_size = s_size[wb_ptr];
        mem_req_data = s_data[wb_ptr];
        alloc_idx    = tail;
        alloc_ready  = !ring_full;
        full         = ring_full;
        empty        = (count == '0);
        pending_wb   = pending_q;
    end

endmodule

// File: rtl/stq_ring_chk.sv
// Checker: temporal properties of the store ring, observed at its ports.
module stq_ring_chk #(
    parameter int CAP   = 7,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             squash_valid,
    input logic             mem_req_valid,
    input logic [IDX_W-1:0] mem_req_idx,
    input logic             mem_req_accept,
    input logic             mem_retry,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] pending_wb
);

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= CAP);

    assert_refusal_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_accept && !mem_retry) |=> !mem_req_valid);

    assert_refusal_holds_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_accept && !squash_valid) |=> $stable(mem_req_idx));

    assert_pending_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending_wb <= count);

    assert_req_needs_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (count != '0));

endmodule

bind stq_ring stq_ring_chk #(
    .CAP  (CAP),
    .IDX_W(IDX_W),
    .CNT_W(CNT_W)
) u_stq_ring_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .squash_valid  (squash_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_idx   (mem_req_idx),
    .mem_req_accept(mem_req_accept),
    .mem_retry     (mem_retry),
    .count         (count),
    .pending_wb    (pending_wb)
);

// File: tb/test_stq_ring.sv
// Directed bench for the store ring: one task per scenario, each checking itself.
module test_stq_ring;

    localparam int CAP    = 7;
    localparam int SLOTS  = 8;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 3;
    localparam int SEQ_W  = 16;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int SIZE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [SEQ_W-1:0]  alloc_seq = '0;
    logic              alloc_ready;
    logic [IDX_W-1:0]  alloc_idx;
    logic              fill_valid = 1'b0;
    logic [IDX_W-1:0]  fill_idx = '0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [SIZE_W-1:0] fill_size = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              commit_valid = 1'b0;
    logic [SEQ_W-1:0]  commit_seq = '0;
    logic              squash_valid = 1'b0;
    logic [SEQ_W-1:0]  squash_seq = '0;
    logic              mem_req_valid;
    logic [IDX_W-1:0]  mem_req_idx;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [SIZE_W-1:0] mem_req_size;
    logic [DATA_W-1:0] mem_req_data;
    logic              mem_req_accept = 1'b0;
    logic              mem_retry = 1'b0;
    logic              mem_ack_valid = 1'b0;
    logic [IDX_W-1:0]  mem_ack_idx = '0;
    logic              wb_blocked;
    logic              full;
    logic              empty;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  pending_wb;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [ADDR_W-1:0] exp_addr [SLOTS];

    always #5 clk = ~clk;

    stq_ring #(.CAP(CAP)) i_stq_ring (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_addr(fill_addr),
        .fill_size(fill_size), .fill_data(fill_data),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .mem_req_valid(mem_req_valid), .mem_req_idx(mem_req_idx),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_req_data(mem_req_data), .mem_req_accept(mem_req_accept),
        .mem_retry(mem_retry), .mem_ack_valid(mem_ack_valid),
        .mem_ack_idx(mem_ack_idx), .wb_blocked(wb_blocked),
        .full(full), .empty(empty), .count(count), .pending_wb(pending_wb)
    );

    // Compare one observed value with its expectation and count the result.
    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Let one rising edge pass and settle just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Allocate one store with the given sequence number.
    task automatic do_alloc(input int seq);
        alloc_valid = 1'b1;
        alloc_seq   = SEQ_W'(seq);
        tick();
        alloc_valid = 1'b0;
    endtask

    // Fill one slot with a payload derived from its index.
    task automatic do_fill(input int idx);
        fill_valid = 1'b1;
        fill_idx   = IDX_W'(idx);
        fill_addr  = ADDR_W'(32'h100 + idx * 8);
        fill_size  = SIZE_W'(8);
        fill_data  = 64'hD0D0_0000_0000_0000 | 64'(idx);
        exp_addr[idx] = fill_addr;
        tick();
        fill_valid = 1'b0;
    endtask

    // Acknowledge completion of one slot.
    task automatic do_ack(input int idx);
        mem_ack_valid = 1'b1;
        mem_ack_idx   = IDX_W'(idx);
        tick();
        mem_ack_valid = 1'b0;
    endtask

    // Scenario: reset leaves the ring empty.
    task automatic t_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        chk("R10", "count", 64'(count), 0);
        chk("R10", "empty", 64'(empty), 1);
        chk("R10", "pending_wb", 64'(pending_wb), 0);
        chk("R10", "mem_req_valid", 64'(mem_req_valid), 0);
        chk("R10", "alloc_idx", 64'(alloc_idx), 0);
    endtask

    // Scenario: fill the ring to capacity, then try one more allocation.
    task automatic t_fill_to_capacity();
        for (int i = 0; i < CAP; i++) begin
            chk("R2", "alloc_idx order", 64'(alloc_idx), 64'(i));
            do_alloc(10 + i);
        end
        chk("R1", "count at capacity", 64'(count), CAP);
        chk("R1", "full", 64'(full), 1);
        chk("R1", "alloc_ready", 64'(alloc_ready), 0);
        do_alloc(99);
        chk("R1", "count after refused alloc", 64'(count), CAP);
        chk("R1", "alloc_idx after refused alloc", 64'(alloc_idx), 7);
        for (int i = 0; i < CAP; i++) do_fill(i);
        chk("R4", "no request before commit", 64'(mem_req_valid), 0);
    endtask

    // Scenario: commit only the three oldest stores.
    task automatic t_partial_commit();
        commit_valid = 1'b1;
        commit_seq   = SEQ_W'(13);
        tick();
        commit_valid = 1'b0;
        chk("R5", "pending_wb after commit", 64'(pending_wb), 3);
        chk("R6", "request valid", 64'(mem_req_valid), 1);
        chk("R6", "first idx", 64'(mem_req_idx), 0);
        chk("R3", "addr", 64'(mem_req_addr), 64'(exp_addr[0]));
        chk("R3", "size", 64'(mem_req_size), 8);
        chk("R3", "data", mem_req_data, 64'hD0D0_0000_0000_0000);
    endtask

    // Scenario: memory refuses, then signals retry.
    task automatic t_refuse_retry();
        mem_req_accept = 1'b0;
        tick();
        chk("R7", "valid dropped", 64'(mem_req_valid), 0);
        chk("R7", "blocked", 64'(wb_blocked), 1);
        chk("R7", "idx held", 64'(mem_req_idx), 0);
        tick();
        tick();
        chk("R7", "still quiet", 64'(mem_req_valid), 0);
        mem_retry = 1'b1;
        tick();
        mem_retry = 1'b0;
        chk("R7", "reissued", 64'(mem_req_valid), 1);
        chk("R7", "same idx", 64'(mem_req_idx), 0);
        chk("R7", "unblocked", 64'(wb_blocked), 0);
    endtask

    // Scenario: drain the committed stores in order.
    task automatic t_inorder_drain();
        mem_req_accept = 1'b1;
        tick();
        chk("R6", "idx 1", 64'(mem_req_idx), 1);
        chk("R3", "addr 1", 64'(mem_req_addr), 64'(exp_addr[1]));
        tick();
        chk("R6", "idx 2", 64'(mem_req_idx), 2);
        tick();
        chk("R6", "idx 3", 64'(mem_req_idx), 3);
        chk("R4", "uncommitted not sent", 64'(mem_req_valid), 0);
        mem_req_accept = 1'b0;
        chk("R5", "pending unchanged by issue", 64'(pending_wb), 3);
    endtask

    // Scenario: out-of-order acknowledgements, head-only release.
    task automatic t_release_order();
        do_ack(1);
        chk("R8", "pending after ack1", 64'(pending_wb), 2);
        chk("R8", "no release behind head", 64'(count), 7);
        do_ack(0);
        chk("R8", "pending after ack0", 64'(pending_wb), 1);
        chk("R8", "release lags ack", 64'(count), 7);
        tick();
        chk("R8", "head 0 released", 64'(count), 6);
        tick();
        chk("R8", "head 1 released", 64'(count), 5);
        do_ack(2);
        chk("R8", "pending after ack2", 64'(pending_wb), 0);
        chk("R8", "count before release 2", 64'(count), 5);
        tick();
        chk("R8", "head 2 released", 64'(count), 4);
    endtask

    // Scenario: squash mid-ring with a simultaneous allocation request.
    task automatic t_squash();
        squash_valid = 1'b1;
        squash_seq   = SEQ_W'(14);
        alloc_valid  = 1'b1;
        alloc_seq    = SEQ_W'(77);
        tick();
        squash_valid = 1'b0;
        alloc_valid  = 1'b0;
        chk("R9", "count after squash", 64'(count), 2);
        chk("R9", "tail pulled back", 64'(alloc_idx), 5);
        chk("R9", "no request", 64'(mem_req_valid), 0);
    endtask

    // Scenario: allocate across the wrap, commit all, drain and retire.
    task automatic t_wrap_drain();
        int exp_slots [6];
        exp_slots = '{3, 4, 5, 6, 7, 0};
        for (int k = 0; k < 4; k++) begin
            chk("R2", "wrap alloc_idx", 64'(alloc_idx), 64'((5 + k) % SLOTS));
            do_alloc(20 + k);
        end
        chk("R2", "tail after wrap", 64'(alloc_idx), 1);
        chk("R9", "count after refill", 64'(count), 6);
        for (int k = 0; k < 4; k++) do_fill((5 + k) % SLOTS);
        commit_valid = 1'b1;
        commit_seq   = SEQ_W'(100);
        tick();
        commit_valid = 1'b0;
        chk("R5", "pending after full commit", 64'(pending_wb), 6);
        mem_req_accept = 1'b1;
        for (int k = 0; k < 6; k++) begin
            chk("R6", "wrap valid", 64'(mem_req_valid), 1);
            chk("R6", "wrap idx", 64'(mem_req_idx), 64'(exp_slots[k]));
            chk("R3", "wrap addr", 64'(mem_req_addr), 64'(exp_addr[exp_slots[k]]));
            tick();
        end
        mem_req_accept = 1'b0;
        chk("R4", "nothing left to send", 64'(mem_req_valid), 0);
        for (int k = 0; k < 6; k++) do_ack(exp_slots[k]);
        tick();
        chk("R8", "all retired", 64'(count), 0);
        chk("R8", "empty", 64'(empty), 1);
        chk("R8", "pending zero", 64'(pending_wb), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // Run the scenarios in order.
    initial begin
        t_reset();
        t_fill_to_capacity();
        t_partial_commit();
        t_refuse_retry();
        t_inorder_drain();
        t_release_order();
        t_squash();
        t_wrap_drain();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule